// File: doc/BRIEF.md
# Immediate-Masked Dword Blend Unit

This block is a vector execution unit that merges two source vectors, 32-bit lane by 32-bit lane, under an 8-bit immediate mask. A set mask bit takes that lane from the second source and a clear bit takes it from the first source. A vector-length select picks between a 128-bit short form and a 256-bit long form. The short form drives every destination bit at or above bit 128 to zero, up to the parameterised maximum vector length. Decoded encoding fields arrive with each operation: the W bit, the opcode byte, the opcode-map code and the implied-prefix code. From these the unit decides whether the operation is a legal blend, an illegal blend that must fault, or not a blend at all.

Operations enter on a valid/ready stream. An operation is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The one-deep output register presents each response on a second valid/ready stream. `in_ready` is high whenever the output slot is empty or is being emptied in the same cycle (`out_ready` high), so an accepted operation responds one cycle later. While `out_valid` is high and `out_ready` is low, the response holds unchanged and new operations are refused.

A response is either a result (`out_result` high, `out_data` carrying the blend) or an invalid-opcode fault (`out_fault` high, `out_data` zero). An operation whose encoding is not the blend is accepted and discarded: it produces no response and no fault.

Top module: `dword_blend_unit`

## Requirements
- R1: For each lane i in use, destination bits 32i+31:32i equal lane i of `src_b` when `imm[i]` is 1 and lane i of `src_a` when `imm[i]` is 0.
- R2: With `vl_long` = 1 (256-bit form), all eight immediate bits are used and a legal operation yields a result covering destination bits 255:0, presented with `out_result` = 1 one cycle after acceptance.
- R3: With `vl_long` = 0 (128-bit form), only `imm[3:0]` are used, and every `out_data` bit from 128 up to MAX_VL-1 is zero in the result.
- R4: In the 128-bit form, `imm[7:4]` have no effect on any output bit.
- R5: The encoding is the blend when `enc_opcode` = 8'h02, `enc_map` = 5'd3 and `enc_pp` = 2'd1. A blend with `enc_w` = 1 responds with `out_fault` = 1, `out_result` = 0 and `out_data` all zero.
- R6: An accepted operation whose opcode, map or prefix code differs from the blend encoding produces no response (`out_valid` stays 0 for it) and no fault.
- R7: `in_ready` = 1 exactly when the output slot is empty or `out_ready` = 1. While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_result`, `out_fault` and `out_data` hold their values.
- R8: After reset, `out_valid`, `out_result` and `out_fault` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| vl_long | input | 1 | 1 selects the 256-bit form, 0 the 128-bit form |
| enc_w | input | 1 | Decoded W bit; must be 0 for a legal blend |
| enc_opcode | input | 8 | Decoded opcode byte |
| enc_map | input | 5 | Decoded opcode-map code |
| enc_pp | input | 2 | Decoded implied-prefix code |
| imm | input | 8 | Lane mask from the immediate byte |
| src_a | input | MAX_VL | First source vector |
| src_b | input | MAX_VL | Second source vector |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response this cycle |
| out_result | output | 1 | Response is a blend result |
| out_fault | output | 1 | Response is an invalid-opcode fault |
| out_data | output | MAX_VL | Destination vector; zero on a fault |

## Verification
The hardest situation to reach is a response held under back-pressure at the moment a new operation is offered: a faulting or discarded operation arriving just behind a stalled result, or a discard accepted in the same cycle that a result leaves. The stimulus holds `out_ready` low for random stretches while operations keep arriving with random lengths, masks, W bits and mismatching encodings. This drives the slot through fill, stall, drain and same-cycle refill. A directed pair of short-form operations that differ only in `imm[7:4]` must give identical results.

// File: rtl/blend_pkg.sv
package blend_pkg;
  localparam int LANE_W      = 32;
  localparam int IMM_W       = 8;
  localparam int SHORT_LANES = 4;
  localparam int LONG_LANES  = 8;

  localparam logic [7:0] BLEND_OPCODE = 8'h02;
  localparam logic [4:0] BLEND_MAP    = 5'd3;
  localparam logic [1:0] BLEND_PP     = 2'd1;

  typedef enum logic [1:0] {
    ENC_OTHER = 2'd0,
    ENC_LEGAL = 2'd1,
    ENC_FAULT = 2'd2
  } enc_kind_e;
endpackage

// File: rtl/blend_decode.sv
module blend_decode
  import blend_pkg::*;
(
  input  logic       enc_w,
  input  logic [7:0] enc_opcode,
  input  logic [4:0] enc_map,
  input  logic [1:0] enc_pp,
  output enc_kind_e  kind
);
  logic is_blend;

  assign is_blend = (enc_opcode == BLEND_OPCODE) &&
                    (enc_map == BLEND_MAP) &&
                    (enc_pp == BLEND_PP);

  always_comb begin
    if (!is_blend)  kind = ENC_OTHER;
    else if (enc_w) kind = ENC_FAULT;
    else            kind = ENC_LEGAL;
  end
endmodule

// File: rtl/blend_lane_mux.sv
module blend_lane_mux
  import blend_pkg::*;
#(
  parameter int MAX_VL = 256
) (
  input  logic [MAX_VL-1:0] src_a,
  input  logic [MAX_VL-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              vl_long,
  output logic [MAX_VL-1:0] dst
);
  localparam int LANES = MAX_VL / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < IMM_W) begin : g_masked
      logic lane_on;
      assign lane_on = vl_long ? (g < LONG_LANES) : (g < SHORT_LANES);
      assign dst[g*LANE_W +: LANE_W] =
        !lane_on  ? '0 :
        imm[g]    ? src_b[g*LANE_W +: LANE_W] :
                    src_a[g*LANE_W +: LANE_W];
    end else begin : g_beyond
      assign dst[g*LANE_W +: LANE_W] = '0;
    end
  end
endmodule

// File: rtl/blend_out_stage.sv
module blend_out_stage #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         load_result,
  input  logic         load_fault,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         slot_free,
  output logic         out_valid,
  output logic         out_result,
  output logic         out_fault,
  output logic [W-1:0] out_data
);
  logic         res_q;
  logic         fault_q;
  logic [W-1:0] data_q;

  assign out_valid  = res_q | fault_q;
  assign out_result = res_q;
  assign out_fault  = fault_q;
  assign out_data   = data_q;
  assign slot_free  = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= 1'b0;
      fault_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      res_q   <= load_result;
      fault_q <= load_fault;
      data_q  <= load_fault ? '0 : load_data;
    end else if (out_ready) begin
      res_q   <= 1'b0;
      fault_q <= 1'b0;
    end
  end

  // R7: a stalled response holds
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_result) && $stable(out_fault)));

  // R5: result and fault never together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_result && out_fault));
endmodule

// File: rtl/dword_blend_unit.sv
module dword_blend_unit
  import blend_pkg::*;
#(
  parameter int MAX_VL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              vl_long,
  input  logic              enc_w,
  input  logic [7:0]        enc_opcode,
  input  logic [4:0]        enc_map,
  input  logic [1:0]        enc_pp,
  input  logic [7:0]        imm,
  input  logic [MAX_VL-1:0] src_a,
  input  logic [MAX_VL-1:0] src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_result,
  output logic              out_fault,
  output logic [MAX_VL-1:0] out_data
);
  localparam int SHORT_W = SHORT_LANES * LANE_W;

  enc_kind_e         kind;
  logic [MAX_VL-1:0] blended;
  logic              accept;

  blend_decode u_decode (
    .enc_w      (enc_w),
    .enc_opcode (enc_opcode),
    .enc_map    (enc_map),
    .enc_pp     (enc_pp),
    .kind       (kind)
  );

  blend_lane_mux #(.MAX_VL(MAX_VL)) u_mux (
    .src_a   (src_a),
    .src_b   (src_b),
    .imm     (imm),
    .vl_long (vl_long),
    .dst     (blended)
  );

  assign accept = in_valid && in_ready;

  blend_out_stage #(.W(MAX_VL)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_result (kind == ENC_LEGAL),
    .load_fault  (kind == ENC_FAULT),
    .load_data   (blended),
    .out_ready   (out_ready),
    .slot_free   (in_ready),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_fault   (out_fault),
    .out_data    (out_data)
  );

  // R2: legal operation yields a result next cycle
  a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == ENC_LEGAL) |=> (out_valid && out_result));

  // R3: short form clears upper destination bits
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == ENC_LEGAL && !vl_long) |=>
      (out_data[MAX_VL-1:SHORT_W] == '0));

  // R5: W set faults with zero data
  a_r5_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == ENC_FAULT) |=>
      (out_fault && !out_result && out_data == '0));

  // R6: other encodings leave no response
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == ENC_OTHER) |=> !out_valid);
endmodule

// File: tb/dword_blend_unit_test.sv
module dword_blend_unit_test;
  localparam int VL = 256;

  typedef struct {
    logic [VL-1:0] a;
    logic [VL-1:0] b;
    logic [7:0]    imm;
    logic          lng;
    logic          w;
    logic [7:0]    opc;
    logic [4:0]    map;
    logic [1:0]    pp;
    string         tag;
  } stim_t;

  typedef struct {
    logic [VL-1:0] data;
    logic          res;
    logic          fault;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic vl_long = 0, enc_w = 0;
  logic [7:0] enc_opcode = 0;
  logic [4:0] enc_map = 0;
  logic [1:0] enc_pp = 0;
  logic [7:0] imm = 0;
  logic [VL-1:0] src_a = 0, src_b = 0;
  logic out_valid, out_ready = 0, out_result, out_fault;
  logic [VL-1:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0;
  stim_t stims[$];
  exp_t  expq[$];

  always #10 clk = ~clk;

  dword_blend_unit #(.MAX_VL(VL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .vl_long(vl_long), .enc_w(enc_w), .enc_opcode(enc_opcode),
    .enc_map(enc_map), .enc_pp(enc_pp), .imm(imm), .src_a(src_a),
    .src_b(src_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_fault(out_fault), .out_data(out_data)
  );

  function automatic logic [VL-1:0] rand_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VL-1:0] ref_blend(stim_t s);
    logic [VL-1:0] d = '0;
    for (int i = 0; i < 8; i++) begin
      if (s.lng || i < 4)
        d[i*32 +: 32] = s.imm[i] ? s.b[i*32 +: 32] : s.a[i*32 +: 32];
    end
    return d;
  endfunction

  function automatic stim_t mk(logic [7:0] m, logic lng, logic w, string tag);
    stim_t s;
    s.a = rand_vec(); s.b = rand_vec(); s.imm = m; s.lng = lng; s.w = w;
    s.opc = 8'h02; s.map = 5'd3; s.pp = 2'd1; s.tag = tag;
    return s;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    stim_t s, cur;
    bit have, prev_stall;
    logic [VL-1:0] prev_data;
    logic prev_res, prev_fault;
    exp_t e;

    // directed stimuli
    s = mk(8'hAA, 1, 0, "R1"); stims.push_back(s);
    s = mk(8'hFF, 1, 0, "R2"); stims.push_back(s);
    s = mk(8'h00, 1, 0, "R2"); stims.push_back(s);
    s = mk(8'h05, 0, 0, "R3"); stims.push_back(s);
    s.imm = 8'hF5; s.tag = "R4"; stims.push_back(s);
    s = mk(8'h3C, 1, 1, "R5"); stims.push_back(s);
    s = mk(8'h11, 1, 0, "R6"); s.opc = 8'h03; stims.push_back(s);
    s = mk(8'h11, 0, 0, "R6"); s.map = 5'd2; stims.push_back(s);
    s = mk(8'h11, 1, 0, "R6"); s.pp = 2'd0; stims.push_back(s);
    for (int k = 0; k < 800; k++) begin
      int r = $urandom_range(0, 9);
      s = mk(8'($urandom), 1'($urandom), (r == 0), "R1");
      if (r == 1) s.opc = 8'($urandom_range(3, 255));
      if (r == 2) s.map = 5'($urandom_range(4, 31));
      if (r == 3) s.pp = 2'($urandom_range(2, 3));
      if (r <= 3 && r >= 1) s.tag = "R6";
      else if (r == 0) s.tag = "R5";
      else if (!s.lng) s.tag = "R3";
      stims.push_back(s);
    end

    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_result == 0 && out_fault == 0, "R8", "reset flags",
          {out_valid, out_result, out_fault}, 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1, "R8", "in_ready after reset", in_ready, 1);

    have = 0; prev_stall = 0;
    while (stims.size() > 0 || have || expq.size() > 0 || out_valid) begin
      @(negedge clk);
      if (!have && stims.size() > 0 && $urandom_range(0, 4) != 0) begin
        cur = stims.pop_front(); have = 1;
      end
      in_valid = have;
      if (have) begin
        src_a = cur.a; src_b = cur.b; imm = cur.imm; vl_long = cur.lng;
        enc_w = cur.w; enc_opcode = cur.opc; enc_map = cur.map; enc_pp = cur.pp;
      end
      out_ready = (stims.size() == 0 && !have) ? 1'b1 : ($urandom_range(0, 2) != 0);
      #1;
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_result == prev_res &&
              out_fault == prev_fault, "R7", "stalled response changed",
              out_data, prev_data);
      check(in_ready == (!out_valid || out_ready), "R7", "in_ready rule",
            in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R6", "unexpected response", out_data, 0);
        end else begin
          e = expq.pop_front();
          check(out_data == e.data && out_result == e.res && out_fault == e.fault,
                e.tag, "response", {out_data}, e.data);
        end
      end
      if (in_valid && in_ready) begin
        if (cur.opc == 8'h02 && cur.map == 5'd3 && cur.pp == 2'd1) begin
          e.tag = cur.tag;
          if (cur.w) begin
            e.data = '0; e.res = 0; e.fault = 1;
          end else begin
            e.data = ref_blend(cur); e.res = 1; e.fault = 0;
          end
          expq.push_back(e);
        end
        have = 0;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data; prev_res = out_result; prev_fault = out_fault;
    end
    in_valid = 0;
    repeat (2) @(negedge clk);
    check(out_valid == 0 && expq.size() == 0, "R6", "drained", out_valid, 0);
    finish_run();
  end
endmodule